// File: doc/BRIEF.md
# Two-Phase Fetch/Execute Processor Core

This block is a compact 32-bit processor that runs a small integer instruction subset: three register-to-register operations (add, subtract, signed set-on-less-than), a word load, a word store, two conditional branches and an unconditional jump. Every instruction occupies exactly two clock cycles. In the first cycle the word addressed by the program counter is captured in an instruction register. In the second cycle the instruction is carried out, its result is committed and the program counter is updated. Code and data live together in one word-wide memory inside the block. The processor addresses that memory in bytes, and the two low address bits are dropped on every access.

A loader port writes memory words directly. It is normally used while reset is held, and reset leaves memory contents untouched. A halt request stops the core at the end of the current execute cycle. Registered debug read ports then expose any register and any memory word, so a program's effect can be inspected. Opcodes and function codes outside the subset execute as no-ops and raise a sticky error flag.

Top module: `twostep_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_q` becomes `START_ADDR` (default 0), `halted` and `bad_op` become 0, and the core enters the fetch cycle.
- R2: Each instruction takes two rising edges. The first captures the word at `pc_q` and leaves `pc_q` unchanged. The second commits the result and moves `pc_q` to the next address, which is `pc_q`+4 when no transfer is taken. `pc_q` stays word aligned.
- R3: Register operations use bits [31:26]=0, with rs in [25:21], rt in [20:16], rd in [15:11] and the function code in [5:0]. Function 32 writes rs+rt to rd and function 34 writes rs-rt, both modulo 2^32. Function 42 writes 1 to rd when rs<rt as signed numbers and 0 otherwise.
- R4: Opcode 35 loads rt with the memory word at rs plus the sign-extended 16-bit field [15:0]. Opcode 43 stores rt at the same address. The word index is address bits [IW+1:2], where IW=log2(MEM_WORDS).
- R5: Opcode 4 transfers when rs equals rt, and opcode 5 transfers when they differ. The target is `pc_q`+4 plus the sign-extended field [15:0] times 4. When the condition fails, execution continues at `pc_q`+4.
- R6: Opcode 2 always transfers to {(`pc_q`+4)[31:28], field [25:0], 2'b00}.
- R7: Register 0 reads as zero, and any write to it is discarded.
- R8: An unknown opcode, or opcode 0 with an unknown function code, changes no register or memory word and advances `pc_q` by 4. It sets `bad_op` one edge after its execute cycle, and `bad_op` stays high until reset.
- R9: If `halt_req` is high at an execute edge, `halted` rises at that edge. `pc_q`, the registers and the memory then stay frozen while `halt_req` stays high. Fetching resumes on the edge after `halt_req` falls.
- R10: When `ld_we` is high at a rising edge, `ld_data` is written to word `ld_idx`. Reset does not clear memory.
- R11: `dbg_reg_q` and `dbg_mem_q` show the register `dbg_reg_sel` and the word `dbg_mem_idx` one rising edge after the selection is applied. Register 0 shows as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Stop at the end of the current execute cycle and hold there |
| ld_we | input | 1 | Loader write enable |
| ld_idx | input | IW | Loader word index |
| ld_data | input | 32 | Loader write data |
| dbg_reg_sel | input | 5 | Register to expose |
| dbg_reg_q | output | 32 | Registered register contents |
| dbg_mem_idx | input | IW | Memory word to expose |
| dbg_mem_q | output | 32 | Registered memory word |
| pc_q | output | 32 | Program counter |
| halted | output | 1 | Core is stopped by a halt request |
| bad_op | output | 1 | Sticky unsupported-instruction flag |

## Verification
After reset is released, the first instruction's program counter update falls on the second rising edge. The bench samples `pc_q` after the first edge, expecting no change, and again after the second, expecting +4. Results of a program are read only after `halted` is seen high, when the state can no longer move. Each debug read places its selection before a rising edge and samples at the falling edge after it, which matches the one-edge latency of the registered debug outputs. The operand sweep allows a fixed margin beyond two cycles per instruction before it halts the core, so every store has committed before any read-back.

// File: rtl/twostep_pkg.sv
package twostep_pkg;
  localparam int XLEN = 32;
  localparam int NREGS = 32;
  localparam int RIDX_W = $clog2(NREGS);

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_EXEC  = 2'd1,
    PH_HALT  = 2'd2
  } phase_t;

  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_JUMP = 6'd2;
  localparam logic [5:0] OPC_BEQ  = 6'd4;
  localparam logic [5:0] OPC_BNE  = 6'd5;
  localparam logic [5:0] OPC_LOAD = 6'd35;
  localparam logic [5:0] OPC_STOR = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;
endpackage

// File: rtl/twostep_regfile.sv
module twostep_regfile
  import twostep_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [RIDX_W-1:0] wa,
  input  logic [XLEN-1:0]   wd,
  input  logic [RIDX_W-1:0] ra,
  input  logic [RIDX_W-1:0] rb,
  input  logic [RIDX_W-1:0] dsel,
  output logic [XLEN-1:0]   qa,
  output logic [XLEN-1:0]   qb,
  output logic [XLEN-1:0]   dq
);
  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
    dq <= (dsel == '0) ? '0 : regs[dsel];
  end

  assign qa = (ra == '0) ? '0 : regs[ra];
  assign qb = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/twostep_mem.sv
module twostep_mem
  import twostep_pkg::*;
#(
  parameter int WORDS = 256,
  localparam int IW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [XLEN-1:0] wdata,
  input  logic [IW-1:0]   ridx,
  output logic [XLEN-1:0] rdata,
  input  logic [IW-1:0]   didx,
  output logic [XLEN-1:0] dq
);
  logic [XLEN-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[widx] <= wdata;
    dq <= store[didx];
  end

  assign rdata = store[ridx];
endmodule

// File: rtl/twostep_exec.sv
module twostep_exec
  import twostep_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic [XLEN-1:0]   ir,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  input  logic [XLEN-1:0]   mem_rd,
  output logic [RIDX_W-1:0] rs_idx,
  output logic [RIDX_W-1:0] rt_idx,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_wa,
  output logic [XLEN-1:0]   rf_wd,
  output logic              st_en,
  output logic [IW-1:0]     mem_idx,
  output logic [XLEN-1:0]   next_pc,
  output logic              bad
);
  logic [5:0]      opc, fn;
  logic [XLEN-1:0] simm, pc4, eaddr, btarget;
  logic            unused_exec;

  assign opc     = ir[31:26];
  assign fn      = ir[5:0];
  assign rs_idx  = ir[25:21];
  assign rt_idx  = ir[20:16];
  assign simm    = {{(XLEN-16){ir[15]}}, ir[15:0]};
  assign pc4     = pc + 32'd4;
  assign eaddr   = rs_val + simm;
  assign btarget = pc4 + {simm[XLEN-3:0], 2'b00};
  assign mem_idx = eaddr[IW+1:2];
  assign unused_exec = ^{eaddr[XLEN-1:IW+2], eaddr[1:0], ir[10:6], simm[XLEN-1:XLEN-2]};

  always_comb begin
    rf_we   = 1'b0;
    rf_wa   = ir[15:11];
    rf_wd   = '0;
    st_en   = 1'b0;
    next_pc = pc4;
    bad     = 1'b0;
    unique case (opc)
      OPC_REG: begin
        unique case (fn)
          FN_ADD: begin rf_we = 1'b1; rf_wd = rs_val + rt_val; end
          FN_SUB: begin rf_we = 1'b1; rf_wd = rs_val - rt_val; end
          FN_SLT: begin
            rf_we = 1'b1;
            rf_wd = {{(XLEN-1){1'b0}}, ($signed(rs_val) < $signed(rt_val))};
          end
          default: bad = 1'b1;
        endcase
      end
      OPC_LOAD: begin rf_we = 1'b1; rf_wa = rt_idx; rf_wd = mem_rd; end
      OPC_STOR: st_en = 1'b1;
      OPC_BEQ:  if (rs_val == rt_val) next_pc = btarget;
      OPC_BNE:  if (rs_val != rt_val) next_pc = btarget;
      OPC_JUMP: next_pc = {pc4[31:28], ir[25:0], 2'b00};
      default:  bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/twostep_cpu.sv
module twostep_cpu
  import twostep_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  parameter logic [31:0] START_ADDR = 32'h0000_0000,
  localparam int IW = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt_req,
  input  logic          ld_we,
  input  logic [IW-1:0] ld_idx,
  input  logic [31:0]   ld_data,
  input  logic [4:0]    dbg_reg_sel,
  output logic [31:0]   dbg_reg_q,
  input  logic [IW-1:0] dbg_mem_idx,
  output logic [31:0]   dbg_mem_q,
  output logic [31:0]   pc_q,
  output logic          halted,
  output logic          bad_op
);
  phase_t      phase;
  logic [31:0] pc_r, ir_r;
  logic        bad_r, halted_r;

  logic [RIDX_W-1:0] rs_idx, rt_idx, x_wa;
  logic [31:0]       rs_val, rt_val, x_wd, x_next, mem_rd;
  logic              x_we, x_st, x_bad;
  logic [IW-1:0]     x_midx, rd_idx, wr_idx;
  logic              in_exec, mem_we;
  logic [31:0]       wr_data;
  logic              unused_pc;

  assign in_exec   = (phase == PH_EXEC);
  assign rd_idx    = (phase == PH_FETCH) ? pc_r[IW+1:2] : x_midx;
  assign mem_we    = ld_we | (x_st & in_exec);
  assign wr_idx    = ld_we ? ld_idx : x_midx;
  assign wr_data   = ld_we ? ld_data : rt_val;
  assign unused_pc = ^{pc_r[31:IW+2], pc_r[1:0]};

  twostep_regfile u_rf (
    .clk(clk), .we(x_we & in_exec), .wa(x_wa), .wd(x_wd),
    .ra(rs_idx), .rb(rt_idx), .dsel(dbg_reg_sel),
    .qa(rs_val), .qb(rt_val), .dq(dbg_reg_q)
  );

  twostep_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .we(mem_we), .widx(wr_idx), .wdata(wr_data),
    .ridx(rd_idx), .rdata(mem_rd), .didx(dbg_mem_idx), .dq(dbg_mem_q)
  );

  twostep_exec #(.IW(IW)) u_exec (
    .ir(ir_r), .pc(pc_r), .rs_val(rs_val), .rt_val(rt_val), .mem_rd(mem_rd),
    .rs_idx(rs_idx), .rt_idx(rt_idx), .rf_we(x_we), .rf_wa(x_wa), .rf_wd(x_wd),
    .st_en(x_st), .mem_idx(x_midx), .next_pc(x_next), .bad(x_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_FETCH;
      pc_r     <= START_ADDR;
      ir_r     <= '0;
      bad_r    <= 1'b0;
      halted_r <= 1'b0;
    end else begin
      unique case (phase)
        PH_FETCH: begin
          ir_r  <= mem_rd;
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          pc_r     <= x_next;
          bad_r    <= bad_r | x_bad;
          phase    <= halt_req ? PH_HALT : PH_FETCH;
          halted_r <= halt_req;
        end
        PH_HALT: begin
          if (!halt_req) begin
            phase    <= PH_FETCH;
            halted_r <= 1'b0;
          end
        end
        default: phase <= PH_FETCH;
      endcase
    end
  end

  assign pc_q   = pc_r;
  assign halted = halted_r;
  assign bad_op = bad_r;

  AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |=> (phase == PH_EXEC)); // R2
  AST_PC_HELD_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |=> $stable(pc_r)); // R2
  AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (pc_r[1:0] == 2'b00)); // R2
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HALT && halt_req) |=> ($stable(pc_r) && phase == PH_HALT)); // R9
  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (rst)
    bad_r |=> bad_r); // R8
endmodule

// File: tb/twostep_cpu_bench.sv
module twostep_cpu_bench;
  localparam int IW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt_req = 1'b0;
  logic        ld_we = 1'b0;
  logic [IW-1:0] ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_reg_sel = '0;
  logic [IW-1:0] dbg_mem_idx = '0;
  logic [31:0] dbg_reg_q, dbg_mem_q, pc_q;
  logic        halted, bad_op;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  twostep_cpu #(.MEM_WORDS(256), .START_ADDR(32'h0)) u_twostep_cpu (
    .clk(clk), .rst(rst), .halt_req(halt_req),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_q(dbg_reg_q),
    .dbg_mem_idx(dbg_mem_idx), .dbg_mem_q(dbg_mem_q),
    .pc_q(pc_q), .halted(halted), .bad_op(bad_op)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [25:0] a);
    return {6'd2, a};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_idx = idx[IW-1:0]; ld_data = d;
    @(posedge clk);
    #2 ld_we = 1'b0;
  endtask

  task automatic rd_reg(input int r, output logic [31:0] v);
    @(negedge clk); dbg_reg_sel = r[4:0];
    @(negedge clk); v = dbg_reg_q;
  endtask
  task automatic rd_mem(input int i, output logic [31:0] v);
    @(negedge clk); dbg_mem_idx = i[IW-1:0];
    @(negedge clk); v = dbg_mem_q;
  endtask

  task automatic stop_core();
    @(negedge clk); halt_req = 1'b1;
    for (int k = 0; k < 10 && !halted; k++) @(negedge clk);
    check("R9 halted", {31'd0, halted}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, p0, p1, a, b;
    logic [31:0] vals [8];
    vals[0] = 32'd0;          vals[1] = 32'd1;
    vals[2] = 32'hFFFF_FFFF;  vals[3] = 32'h7FFF_FFFF;
    vals[4] = 32'h8000_0000;  vals[5] = 32'd23;
    vals[6] = 32'hFFFF_FFE9;  vals[7] = 32'h1234_5678;

    // operand sweep program; R4 word index = byte address >> 2
    load(0, enc_i(6'd35, 5'd0, 5'd1, 16'h0200));
    load(1, enc_i(6'd35, 5'd0, 5'd2, 16'h0204));
    load(2, enc_r(5'd1, 5'd2, 5'd3, 6'd32));
    load(3, enc_r(5'd1, 5'd2, 5'd4, 6'd34));
    load(4, enc_r(5'd1, 5'd2, 5'd5, 6'd42));
    load(5, enc_r(5'd2, 5'd1, 5'd6, 6'd42));
    load(6, enc_i(6'd43, 5'd0, 5'd3, 16'h0208));
    load(7, enc_i(6'd43, 5'd0, 5'd4, 16'h020C));
    load(8, enc_i(6'd43, 5'd0, 5'd5, 16'h0210));
    load(9, enc_i(6'd43, 5'd0, 5'd6, 16'h0214));
    load(10, enc_i(6'd4, 5'd0, 5'd0, 16'hFFFF));

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        a = vals[i]; b = vals[j];
        @(negedge clk); rst = 1'b1; halt_req = 1'b0;
        load(128, a);
        load(129, b);
        @(negedge clk);
        if (i == 0 && j == 0) begin
          check("R1 pc reset", pc_q, 32'h0);
          check("R1 halted reset", {31'd0, halted}, 32'd0);
          check("R1 bad_op reset", {31'd0, bad_op}, 32'd0);
        end
        rst = 1'b0;
        repeat (30) @(negedge clk);
        stop_core();
        rd_mem(130, v); check("R3 add / R4 store", v, a + b);
        rd_mem(131, v); check("R3 sub", v, a - b);
        rd_mem(132, v); check("R3 slt a<b", v, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        rd_mem(133, v); check("R3 slt b<a", v, ($signed(b) < $signed(a)) ? 32'd1 : 32'd0);
      end
    end
    check("R5 beq backward loop pc", pc_q, 32'h28);
    check("R8 no flag on legal code", {31'd0, bad_op}, 32'd0);

    // control-flow program
    @(negedge clk); rst = 1'b1; halt_req = 1'b0;
    load(0,  enc_i(6'd35, 5'd0, 5'd7, 16'h0204));
    load(1,  enc_i(6'd35, 5'd0, 5'd8, 16'h0200));
    load(2,  enc_i(6'd35, 5'd8, 5'd9, 16'h0000));
    load(3,  enc_r(5'd9, 5'd7, 5'd9, 6'd32));
    load(4,  enc_i(6'd43, 5'd8, 5'd9, 16'h0008));
    load(5,  enc_r(5'd7, 5'd9, 5'd10, 6'd34));
    load(6,  enc_r(5'd10, 5'd7, 5'd11, 6'd42));
    load(7,  enc_r(5'd7, 5'd10, 5'd12, 6'd42));
    load(8,  enc_r(5'd7, 5'd7, 5'd0, 6'd32));
    load(9,  enc_i(6'd4, 5'd11, 5'd11, 16'h0001));
    load(10, enc_r(5'd7, 5'd7, 5'd11, 6'd32));
    load(11, enc_i(6'd5, 5'd12, 5'd0, 16'h0001));
    load(12, enc_r(5'd7, 5'd7, 5'd14, 6'd32));
    load(13, enc_j(26'd15));
    load(14, enc_r(5'd7, 5'd7, 5'd12, 6'd32));
    load(15, 32'hFC00_0000);
    load(16, enc_r(5'd7, 5'd0, 5'd16, 6'd32));
    load(17, enc_i(6'd5, 5'd7, 5'd0, 16'hFFFF));
    load(128, 32'h0000_0210);
    load(129, 32'd23);
    load(132, 32'd21);
    load(134, 32'h0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); p0 = pc_q;
    @(negedge clk); p1 = pc_q;
    check("R2 pc held after fetch edge", p0, 32'h0);
    check("R2 pc +4 after execute edge", p1, 32'h4);
    repeat (60) @(negedge clk);
    stop_core();
    check("R5 R6 final loop pc", pc_q, 32'h44);
    check("R8 bad_op raised", {31'd0, bad_op}, 32'd1);
    rd_reg(9, v);  check("R4 R3 loaded word plus reg", v, 32'd44);
    rd_mem(134, v); check("R4 store at base+8", v, 32'd44);
    rd_reg(10, v); check("R3 sub negative", v, 32'hFFFF_FFEB);
    rd_reg(11, v); check("R5 beq taken skips write", v, 32'd1);
    rd_reg(14, v); check("R5 bne not taken falls through", v, 32'd46);
    rd_reg(12, v); check("R6 jump skips write", v, 32'd0);
    rd_reg(16, v); check("R8 execution resumes after bad code", v, 32'd23);
    rd_reg(0, v);  check("R7 r0 stays zero", v, 32'd0);
    rd_reg(7, v);  check("R11 debug register read", v, 32'd23);

    // frozen while halted, then resume and reset keeps memory
    p0 = pc_q;
    repeat (5) @(negedge clk);
    check("R9 pc frozen", pc_q, p0);
    halt_req = 1'b0;
    @(negedge clk);
    check("R9 halted drops", {31'd0, halted}, 32'd0);
    rst = 1'b1;
    @(negedge clk);
    check("R8 bad_op cleared by reset", {31'd0, bad_op}, 32'd0);
    rd_mem(129, v); check("R10 memory kept through reset", v, 32'd23);
    load(200, 32'hA5A5_0F0F);
    rd_mem(200, v); check("R10 R11 loader write read back", v, 32'hA5A5_0F0F);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule